// File: doc/BRIEF.md
# Interleaved-Converter Sampling Skew Estimator

This block listens to the merged output of a four-way interleaved converter, after offset and gain have been trimmed. It works out how far the sampling instants of channels 2, 3 and 4 sit from their ideal slots, measured against channel 1. The method is blind. For a channel under test, it takes the absolute step from the neighbour sample just before it and the absolute step to the neighbour sample just after it. Over many samples the imbalance between these two steps follows the skew. Each imbalance is scaled down by a power-of-two step and added into a saturating accumulator. The accumulator value is the skew estimate, normalised to the aggregate sampling period and handed to a fractional-delay corrector.

Channel 3 is measured first, with channel 1 on both sides of it. Channels 2 and 4 use channel 3 as one of their neighbours, so their accumulators are held until a programmable number of channel-3 updates have occurred. Each sample arrives with a two-bit channel tag. An update happens once per complete, in-order frame, at the moment the following frame's channel-1 sample is accepted.

Top module: `skew_estimator`

## Requirements
- R1: While reset is high and after it is released, all three estimates are zero and `ref_locked` is low.
- R2: Tags 0, 1, 2 and 3 mean channels 1, 2, 3 and 4. An update happens when a tag-0 sample `n1` is accepted and the previous frame delivered tags 0,1,2,3 in order. On that edge `skew_ch3` becomes sat(`skew_ch3` + ((|c3−c1| − |n1−c3|) >>> `step_shift`)), where c1 and c3 are that frame's samples. The `>>>` is an arithmetic (floor) shift. Estimates change at no other time.
- R3: On an update edge while `ref_locked` is already high, `skew_ch2` becomes sat(`skew_ch2` + ((|c2−c1| − |c3−c2|) >>> `step_shift`)).
- R4: On an update edge while `ref_locked` is already high, `skew_ch4` becomes sat(`skew_ch4` + ((|c4−c3| − |n1−c4|) >>> `step_shift`)).
- R5: `ref_locked` rises on the update edge that makes the update count reach `settle_limit`, and then stays high until reset. While `ref_locked` is low, `skew_ch2` and `skew_ch4` do not change.
- R6: Estimates are signed, with LSB 2^−FRAC of a sampling period. sat() clamps them to the closed range ±2^(FRAC−1), which is ±0.5 period.
- R7: A non-zero tag that is not the next expected one voids the current frame. The next tag-0 sample then makes no update and starts a new frame.
- R8: A cycle with `in_valid` low changes no estimate, no lock state and no stored sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_chan | input | 2 | Channel tag of the sample (0 = channel 1) |
| in_data | input | DATA_W | Signed corrected sample |
| step_shift | input | SHIFT_W | LMS step as a right-shift amount |
| settle_limit | input | CNT_W | Channel-3 updates required before channels 2/4 adapt |
| skew_ch2 | output | EST_W | Signed skew estimate, channel 2 |
| skew_ch3 | output | EST_W | Signed skew estimate, channel 3 |
| skew_ch4 | output | EST_W | Signed skew estimate, channel 4 |
| ref_locked | output | 1 | Channel-3 reference has settled |

## Verification
The bench builds the block with EST_W=12 and FRAC=10. This puts the clamp at ±512 LSB. A single full-scale step difference with a zero shift then drives an accumulator into either rail, so both saturation corners are reached in two frames. With settle_limit=2, the hand-off from channel-3-only adaptation to all-lane adaptation is seen early in the directed part. The random part then uses a limit of 25, so the freeze of channels 2 and 4 and the lock edge also appear under random frames, broken tag order and idle cycles.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic [1:0] {
    TAG_CH1 = 2'd0,
    TAG_CH2 = 2'd1,
    TAG_CH3 = 2'd2,
    TAG_CH4 = 2'd3
  } chan_tag_e;

  localparam int NUM_LANES = 3;
  localparam int LANE_CH2  = 0;
  localparam int LANE_CH3  = 1;
  localparam int LANE_CH4  = 2;
endpackage

// File: rtl/skew_frame_capture.sv
module skew_frame_capture
  import skew_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [1:0]             in_chan,
  input  logic [DATA_W-1:0]      in_data,
  output logic [3:0][DATA_W-1:0] frame_q,
  output logic                   upd
);
  logic       good_q;
  logic [1:0] next_tag_q;

  assign upd = in_valid && (in_chan == TAG_CH1) && good_q && (next_tag_q == TAG_CH1);

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q     <= 1'b0;
      next_tag_q <= TAG_CH1;
      frame_q    <= '0;
    end else if (in_valid) begin
      if (in_chan == TAG_CH1) begin
        frame_q[0] <= in_data;
        good_q     <= 1'b1;
        next_tag_q <= TAG_CH2;
      end else if (good_q && (in_chan == next_tag_q)) begin
        frame_q[in_chan] <= in_data;
        next_tag_q       <= next_tag_q + 2'd1;
      end else begin
        good_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/skew_lms_lane.sv
module skew_lms_lane #(
  parameter int DATA_W  = 12,
  parameter int EST_W   = 16,
  parameter int FRAC    = 14,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] prev_s,
  input  logic signed [DATA_W-1:0] mid_s,
  input  logic signed [DATA_W-1:0] next_s,
  input  logic [SHIFT_W-1:0]       shift,
  output logic signed [EST_W-1:0]  est
);
  localparam int DW    = DATA_W + 2;
  localparam int SUM_W = ((EST_W > DW) ? EST_W : DW) + 1;
  localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'(1) << (FRAC - 1);
  localparam logic signed [SUM_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [DATA_W:0]   lead, trail, lead_abs, trail_abs;
  logic signed [DW-1:0]     imbal;
  logic signed [SUM_W-1:0]  imbal_x, step, sum;

  always_comb begin
    lead      = {mid_s[DATA_W-1], mid_s} - {prev_s[DATA_W-1], prev_s};
    trail     = {next_s[DATA_W-1], next_s} - {mid_s[DATA_W-1], mid_s};
    lead_abs  = lead[DATA_W]  ? -lead  : lead;
    trail_abs = trail[DATA_W] ? -trail : trail;
    imbal     = {lead_abs[DATA_W], lead_abs} - {trail_abs[DATA_W], trail_abs};
    imbal_x   = {{(SUM_W-DW){imbal[DW-1]}}, imbal};
    step      = imbal_x >>> shift;
    sum       = {{(SUM_W-EST_W){est[EST_W-1]}}, est} + step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      est <= '0;
    end else if (en) begin
      if (sum > POS_LIM)      est <= POS_LIM[EST_W-1:0];
      else if (sum < NEG_LIM) est <= NEG_LIM[EST_W-1:0];
      else                    est <= sum[EST_W-1:0];
    end
  end
endmodule

// File: rtl/skew_settle_ctrl.sv
module skew_settle_ctrl #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [CNT_W-1:0] limit,
  output logic             locked
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      locked <= 1'b0;
    end else if (upd) begin
      if (!cnt_nx[CNT_W]) cnt_q <= cnt_nx[CNT_W-1:0];
      if (cnt_nx >= {1'b0, limit}) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/skew_estimator.sv
module skew_estimator
  import skew_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int EST_W   = 16,
  parameter int FRAC    = 14,
  parameter int SHIFT_W = 4,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_chan,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [SHIFT_W-1:0] step_shift,
  input  logic [CNT_W-1:0]   settle_limit,
  output logic [EST_W-1:0]   skew_ch2,
  output logic [EST_W-1:0]   skew_ch3,
  output logic [EST_W-1:0]   skew_ch4,
  output logic               ref_locked
);
  logic [3:0][DATA_W-1:0] frame_q;
  logic                   upd;
  logic [DATA_W-1:0]      tap_prev [NUM_LANES];
  logic [DATA_W-1:0]      tap_mid  [NUM_LANES];
  logic [DATA_W-1:0]      tap_next [NUM_LANES];
  logic [EST_W-1:0]       est_a    [NUM_LANES];

  skew_frame_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .frame_q(frame_q), .upd(upd)
  );

  skew_settle_ctrl #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst(rst), .upd(upd), .limit(settle_limit), .locked(ref_locked)
  );

  // Neighbour taps: channel 3 sits between two channel-1 samples,
  // channels 2 and 4 lean on channel 3 as one neighbour.
  always_comb begin
    tap_prev[LANE_CH2] = frame_q[0];
    tap_mid [LANE_CH2] = frame_q[1];
    tap_next[LANE_CH2] = frame_q[2];
    tap_prev[LANE_CH3] = frame_q[0];
    tap_mid [LANE_CH3] = frame_q[2];
    tap_next[LANE_CH3] = in_data;
    tap_prev[LANE_CH4] = frame_q[2];
    tap_mid [LANE_CH4] = frame_q[3];
    tap_next[LANE_CH4] = in_data;
  end

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    logic lane_en;
    if (gi == LANE_CH3) begin : g_ref
      assign lane_en = upd;
    end else begin : g_dep
      assign lane_en = upd && ref_locked;
    end
    skew_lms_lane #(
      .DATA_W(DATA_W), .EST_W(EST_W), .FRAC(FRAC), .SHIFT_W(SHIFT_W)
    ) u_lane (
      .clk(clk), .rst(rst), .en(lane_en),
      .prev_s(tap_prev[gi]), .mid_s(tap_mid[gi]), .next_s(tap_next[gi]),
      .shift(step_shift), .est(est_a[gi])
    );
  end

  assign skew_ch2 = est_a[LANE_CH2];
  assign skew_ch3 = est_a[LANE_CH3];
  assign skew_ch4 = est_a[LANE_CH4];
endmodule

// File: rtl/skew_estimator_chk.sv
module skew_estimator_chk #(
  parameter int EST_W = 16,
  parameter int FRAC  = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_chan,
  input logic [EST_W-1:0] skew_ch2,
  input logic [EST_W-1:0] skew_ch3,
  input logic [EST_W-1:0] skew_ch4,
  input logic             ref_locked
);
  localparam int HALF = 1 << (FRAC - 1);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(skew_ch2) && $stable(skew_ch3) && $stable(skew_ch4) && $stable(ref_locked))); // R8

  AST_ONLY_AT_CH1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_chan != 2'd0) |=> ($stable(skew_ch2) && $stable(skew_ch3) && $stable(skew_ch4))); // R2

  AST_DEP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !ref_locked |=> ($stable(skew_ch2) && $stable(skew_ch4))); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ref_locked |=> ref_locked); // R5

  AST_EST_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'($signed(skew_ch2)) <= HALF) && (int'($signed(skew_ch2)) >= -HALF) &&
    (int'($signed(skew_ch3)) <= HALF) && (int'($signed(skew_ch3)) >= -HALF) &&
    (int'($signed(skew_ch4)) <= HALF) && (int'($signed(skew_ch4)) >= -HALF)); // R6
endmodule

bind skew_estimator skew_estimator_chk #(.EST_W(EST_W), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
  .skew_ch2(skew_ch2), .skew_ch3(skew_ch3), .skew_ch4(skew_ch4),
  .ref_locked(ref_locked)
);

// File: tb/skew_estimator_tb.sv
module skew_estimator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 12;
  localparam int EST_W   = 12;
  localparam int FRAC    = 10;
  localparam int SHIFT_W = 4;
  localparam int CNT_W   = 8;
  localparam int HALF    = 1 << (FRAC - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_chan = 2'd0;
  logic [DATA_W-1:0] in_data = '0;
  logic [SHIFT_W-1:0] step_shift = '0;
  logic [CNT_W-1:0] settle_limit = '0;
  logic [EST_W-1:0] skew_ch2, skew_ch3, skew_ch4;
  logic ref_locked;

  int total = 0;
  int bad = 0;
  int m_r[4];
  int m2, m3, m4, m_cnt, m_exp;
  bit m_good, m_locked;

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_estimator #(
    .DATA_W(DATA_W), .EST_W(EST_W), .FRAC(FRAC), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .step_shift(step_shift), .settle_limit(settle_limit),
    .skew_ch2(skew_ch2), .skew_ch3(skew_ch3), .skew_ch4(skew_ch4), .ref_locked(ref_locked)
  );

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int imbal(int p, int m, int n);
    return iabs(m - p) - iabs(n - m);
  endfunction

  function automatic int sat(int v);
    if (v > HALF) return HALF;
    if (v < -HALF) return -HALF;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 skew_ch3", int'($signed(skew_ch3)), m3);
    chk("R3 skew_ch2", int'($signed(skew_ch2)), m2);
    chk("R4 skew_ch4", int'($signed(skew_ch4)), m4);
    chk("R5 ref_locked", int'(ref_locked), int'(m_locked));
  endtask

  task automatic model_reset();
    m2 = 0; m3 = 0; m4 = 0; m_cnt = 0; m_exp = 0;
    m_good = 0; m_locked = 0;
    for (int i = 0; i < 4; i++) m_r[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    chk("R1 skew_ch3 in reset", int'($signed(skew_ch3)), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 skew_ch2", int'($signed(skew_ch2)), 0);
    chk("R1 skew_ch4", int'($signed(skew_ch4)), 0);
    chk("R1 ref_locked", int'(ref_locked), 0);
  endtask

  // Drive at a falling edge, model the next rising edge, compare at the following falling edge.
  task automatic push(bit v, int tag, int data);
    int sh;
    in_valid = v; in_chan = 2'(tag); in_data = DATA_W'(data);
    sh = int'(step_shift);
    if (v) begin
      if (tag == 0) begin
        if (m_good && m_exp == 0) begin
          m3 = sat(m3 + (imbal(m_r[0], m_r[2], data) >>> sh));
          if (m_locked) begin
            m2 = sat(m2 + (imbal(m_r[0], m_r[1], m_r[2]) >>> sh));
            m4 = sat(m4 + (imbal(m_r[2], m_r[3], data) >>> sh));
          end
          m_cnt++;
          if (m_cnt >= int'(settle_limit)) m_locked = 1;
        end
        m_r[0] = data; m_good = 1; m_exp = 1;
      end else if (m_good && tag == m_exp) begin
        m_r[tag] = data; m_exp = (m_exp + 1) % 4;
      end else begin
        m_good = 0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tag, data;
    void'($urandom(32'd2024));
    model_reset();
    step_shift = '0;
    settle_limit = CNT_W'(2);
    do_reset();

    // Positive rail: full-scale lead step, zero trail step.
    push(1, 0, -2048); push(1, 1, 0); push(1, 2, 2047); push(1, 3, 0);
    push(1, 0, 2047);
    chk("R6 positive clamp", int'($signed(skew_ch3)), 512);
    chk("R5 not locked after 1 update", int'(ref_locked), 0);
    // Negative rail, lock rises, channels 2/4 still frozen on this edge.
    push(1, 1, 2047); push(1, 2, 2047); push(1, 3, 2047);
    push(1, 0, -2048);
    chk("R6 negative clamp", int'($signed(skew_ch3)), -512);
    chk("R5 lock at limit", int'(ref_locked), 1);
    chk("R5 ch2 frozen on lock edge", int'($signed(skew_ch2)), 0);
    // Broken tag order voids the frame.
    push(1, 1, 0); push(1, 3, 5); push(1, 2, 0);
    push(1, 0, 100);
    chk("R7 no update after bad order", int'($signed(skew_ch3)), -512);
    // Idle cycle carrying a tag-0 sample must not replace the stored channel-1 value.
    push(0, 0, -2048);
    chk("R8 idle ignored", int'($signed(skew_ch3)), -512);
    push(1, 1, 400); push(1, 2, 500); push(1, 3, -100);
    push(1, 0, 100);
    chk("R3 ch2 directed", int'($signed(skew_ch2)), 200);
    chk("R4 ch4 directed", int'($signed(skew_ch4)), 400);
    chk("R2 ch3 directed", int'($signed(skew_ch3)), -512);

    // Random phase with a longer settle window.
    settle_limit = CNT_W'(25);
    do_reset();
    tag = 0;
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) step_shift = SHIFT_W'(2 + $urandom_range(0, 4));
      data = int'($urandom_range(0, 4095)) - 2048;
      if ($urandom_range(0, 99) < 6) tag = int'($urandom_range(0, 3));
      push($urandom_range(0, 99) < 88, tag, data);
      if (in_chan == 2'(tag)) tag = (tag + 1) % 4;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule